// File: doc/BRIEF.md
# Complementary Channel Control Shadow Register

This block keeps the output control word of every timer channel: a channel enable, a complementary enable and a multi-bit output-control mode. The lower-numbered channels have complementary outputs. For them, software writes can be staged in a preload copy. The staged value moves into the active copy only on a commutation event. The remaining channels always take software writes at once.

A commutation event comes from one of two sources. The first is the software commutation bit, which clears itself. The second, when the update-source select is 1, is a rising edge on the slave trigger input. When the buffer-enable input is low, every channel, complementary or not, takes writes straight into its active copy. The active words are registered and feed the output stage directly.

Top module: `comp_ctrl_shadow`

## Requirements
- R1: While `rst` is high, every active control word and `comm_flag` are 0 after the next clock edge.
- R2: A write to a channel with index NUM_COMP or higher appears on its slice of `act_word` one clock edge later, whatever the value of `buf_en`.
- R3: With `buf_en` = 0, a write to a complementary channel (index below NUM_COMP) appears on its active slice one clock edge later.
- R4: With `buf_en` = 1, a write to a complementary channel changes only its preload copy. Its active slice holds until a commutation event.
- R5: `comm_flag` is 1 in the cycle after a cycle with `comm_set` high. It returns to 0 one cycle later unless `comm_set` is asserted again.
- R6: A `comm_set` pulse in cycle t loads every complementary channel's preload copy into its active slice at the end of cycle t+1, so the new value is visible in cycle t+2.
- R7: With `trig_sel` = 1, a cycle in which `trgin` is sampled high after a low sample produces the same load, visible two clock edges after `trgin` first goes high.
- R8: With `trig_sel` = 0, `trgin` transitions never change any active slice.
- R9: `trgin` held high produces exactly one load. Later buffered writes stay staged until `trgin` falls and rises again.
- R10: When a buffered write and a commutation load fall in the same cycle, the active slice takes the old preload value. The new value stays staged for the next event.
- R11: Word layout: `wr_data` and each slice of `act_word` (channel c at bits [c*W +: W], W = MODE_W+2) carry the channel enable at bit MODE_W+1, the complementary enable at bit MODE_W, and the mode at bits MODE_W-1:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software write strobe for one control word |
| wr_ch | input | CH_W | Index of the channel written |
| wr_data | input | W | Control word written (layout in R11) |
| buf_en | input | 1 | 1: complementary channels stage writes in preload |
| trig_sel | input | 1 | 1: trigger rising edge is also a commutation source |
| comm_set | input | 1 | Software writes 1 to the commutation bit |
| trgin | input | 1 | Slave trigger input |
| act_word | output | NUM_CH*W | Active control words of all channels |
| comm_flag | output | 1 | Read-back of the self-clearing commutation bit |

## Verification
On every cycle, the assertions check the immediate-write paths (R2, R3), the hold of buffered active words between events (R4), the self-clear timing of the commutation bit (R5), that the trigger has no effect when it is not selected (R8), and the reset clear (R1). Four behaviours depend on a chain of inputs spread over many cycles, and only the bench scenarios, compared against the reference model, can show them. These are: the value that lands in the active copy after a staged write, the single load from a trigger held high, the race between a write and a load in the same cycle, and the re-arming of the edge detector.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  // Control word: {chan_en, comp_en, mode[MODE_W-1:0]}
  function automatic int ctl_width(input int mode_w);
    return mode_w + 2;
  endfunction

  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_SW   = 2'b01,
    SRC_TRIG = 2'b10,
    SRC_BOTH = 2'b11
  } evt_src_e;
endpackage

// File: rtl/ccs_evt_gen.sv
module ccs_evt_gen (
  input  logic clk,
  input  logic rst,
  input  logic comm_set,
  input  logic trgin,
  input  logic trig_sel,
  output logic evt,
  output logic comm_flag
);
  import ccs_pkg::*;

  logic     sw_q;
  logic     trg_s;
  logic     trg_d;
  evt_src_e src;

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_q  <= 1'b0;
      trg_s <= 1'b0;
      trg_d <= 1'b0;
    end else begin
      sw_q  <= comm_set;
      trg_s <= trgin;
      trg_d <= trg_s;
    end
  end

  always_comb begin
    src = evt_src_e'({trig_sel & trg_s & ~trg_d, sw_q});
    evt = (src != SRC_NONE);
  end

  assign comm_flag = sw_q;
endmodule

// File: rtl/ccs_channel.sv
module ccs_channel #(
  parameter int W       = 5,
  parameter bit IS_COMP = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_hit,
  input  logic [W-1:0] wr_data,
  input  logic         buf_en,
  input  logic         load,
  output logic [W-1:0] act_o
);
  logic [W-1:0] act_q;

  generate
    if (IS_COMP) begin : g_comp
      logic [W-1:0] pre_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          pre_q <= '0;
          act_q <= '0;
        end else begin
          if (wr_hit) pre_q <= wr_data;
          if (wr_hit && !buf_en) act_q <= wr_data;
          else if (load)         act_q <= pre_q;
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)         act_q <= '0;
        else if (wr_hit) act_q <= wr_data;
      end
    end
  endgenerate

  assign act_o = act_q;
endmodule

// File: rtl/comp_ctrl_shadow.sv
module comp_ctrl_shadow #(
  parameter int NUM_CH   = 4,
  parameter int NUM_COMP = 3,
  parameter int MODE_W   = 3,
  localparam int W       = ccs_pkg::ctl_width(MODE_W),
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [W-1:0]      wr_data,
  input  logic              buf_en,
  input  logic              trig_sel,
  input  logic              comm_set,
  input  logic              trgin,
  output logic [NUM_CH*W-1:0] act_word,
  output logic              comm_flag
);
  logic evt;

  ccs_evt_gen u_evt (
    .clk      (clk),
    .rst      (rst),
    .comm_set (comm_set),
    .trgin    (trgin),
    .trig_sel (trig_sel),
    .evt      (evt),
    .comm_flag(comm_flag)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic hit;
      assign hit = wr_en && (wr_ch == CH_W'(c));
      ccs_channel #(
        .W      (W),
        .IS_COMP(c < NUM_COMP)
      ) u_ch (
        .clk    (clk),
        .rst    (rst),
        .wr_hit (hit),
        .wr_data(wr_data),
        .buf_en (buf_en),
        .load   (evt),
        .act_o  (act_word[c*W +: W])
      );
    end
  endgenerate
endmodule

// File: rtl/ccs_checker.sv
module ccs_checker #(
  parameter int NUM_CH   = 4,
  parameter int NUM_COMP = 3,
  parameter int W        = 5,
  parameter int CH_W     = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [CH_W-1:0]   wr_ch,
  input logic [W-1:0]      wr_data,
  input logic              buf_en,
  input logic              trig_sel,
  input logic              comm_set,
  input logic [NUM_CH*W-1:0] act_word,
  input logic              comm_flag,
  input logic              evt
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (act_word == '0 && !comm_flag));

  assert_flag_set_R5: assert property (@(posedge clk) disable iff (rst)
    comm_set |=> comm_flag);

  assert_flag_clear_R5: assert property (@(posedge clk) disable iff (rst)
    !comm_set |=> !comm_flag);

  assert_trig_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (!trig_sel && !comm_flag && !wr_en) |=> $stable(act_word));

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      if (c < NUM_COMP) begin : g_comp
        assert_direct_write_R3: assert property (@(posedge clk) disable iff (rst)
          (!buf_en && wr_en && wr_ch == CH_W'(c)) |=>
            act_word[c*W +: W] == $past(wr_data));
        assert_buffer_hold_R4: assert property (@(posedge clk) disable iff (rst)
          (buf_en && !evt) |=> $stable(act_word[c*W +: W]));
      end else begin : g_plain
        assert_plain_write_R2: assert property (@(posedge clk) disable iff (rst)
          (wr_en && wr_ch == CH_W'(c)) |=>
            act_word[c*W +: W] == $past(wr_data));
      end
    end
  endgenerate
endmodule

bind comp_ctrl_shadow ccs_checker #(
  .NUM_CH  (NUM_CH),
  .NUM_COMP(NUM_COMP),
  .W       (W),
  .CH_W    (CH_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .wr_ch    (wr_ch),
  .wr_data  (wr_data),
  .buf_en   (buf_en),
  .trig_sel (trig_sel),
  .comm_set (comm_set),
  .act_word (act_word),
  .comm_flag(comm_flag),
  .evt      (evt)
);

// File: tb/sim_comp_ctrl_shadow.sv
module sim_comp_ctrl_shadow;
  localparam int NUM_CH   = 4;
  localparam int NUM_COMP = 3;
  localparam int MODE_W   = 3;
  localparam int W        = MODE_W + 2;
  localparam int CH_W     = 2;

  logic clk = 1'b0;
  logic rst, wr_en, buf_en, trig_sel, comm_set, trgin;
  logic [CH_W-1:0] wr_ch;
  logic [W-1:0] wr_data;
  logic [NUM_CH*W-1:0] act_word;
  logic comm_flag;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  comp_ctrl_shadow #(.NUM_CH(NUM_CH), .NUM_COMP(NUM_COMP), .MODE_W(MODE_W)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data),
    .buf_en(buf_en), .trig_sel(trig_sel), .comm_set(comm_set), .trgin(trgin),
    .act_word(act_word), .comm_flag(comm_flag)
  );

  // Behavioural reference model
  logic [W-1:0] m_pre [NUM_CH];
  logic [W-1:0] m_act [NUM_CH];
  bit m_sw, m_ts, m_td;

  always @(posedge clk) begin
    automatic bit ev = m_sw || (trig_sel && m_ts && !m_td);
    if (rst) begin
      for (int c = 0; c < NUM_CH; c++) begin m_pre[c] = '0; m_act[c] = '0; end
      m_sw = 0; m_ts = 0; m_td = 0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        automatic bit hit = wr_en && (int'(wr_ch) == c);
        if (c < NUM_COMP) begin
          if (hit && !buf_en) m_act[c] = wr_data;
          else if (ev)        m_act[c] = m_pre[c];
          if (hit) m_pre[c] = wr_data;
        end else if (hit) begin
          m_act[c] = wr_data;
        end
      end
      m_sw = comm_set;
      m_td = m_ts;
      m_ts = trgin;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (!done && cycles > 2) begin
      for (int c = 0; c < NUM_CH; c++)
        check(cur_req, 64'(act_word[c*W +: W]), 64'(m_act[c]));
      check(cur_req, 64'(comm_flag), 64'(m_sw));
    end
    if (!done && cycles > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [W-1:0] slice(input int c);
    return act_word[c*W +: W];
  endfunction

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input int c, input logic [W-1:0] d);
    wr_en = 1; wr_ch = CH_W'(c); wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic pulse_comm();
    comm_set = 1; tick(); comm_set = 0;
  endtask

  initial begin
    rst = 1; wr_en = 0; wr_ch = '0; wr_data = '0; buf_en = 0;
    trig_sel = 0; comm_set = 0; trgin = 0;
    tick(3);
    cur_req = "R1";
    check("R1", 64'(act_word), 64'(0));
    check("R1", 64'(comm_flag), 64'(0));
    rst = 0;
    tick();

    // R11 word layout: en at bit 4, cen at bit 3, mode at 2:0
    cur_req = "R3";
    do_write(0, 5'b10_101);
    check("R3", 64'(slice(0)), 64'(5'h15));
    check("R11", 64'(act_word[4]), 64'(1));

    cur_req = "R2";
    buf_en = 1;
    do_write(3, 5'b11_011);
    check("R2", 64'(slice(3)), 64'(5'h1b));

    cur_req = "R4";
    do_write(1, 5'b01_110);
    tick(3);
    check("R4", 64'(slice(1)), 64'(0));

    cur_req = "R5";
    pulse_comm();
    check("R5", 64'(comm_flag), 64'(1));
    tick();
    check("R5", 64'(comm_flag), 64'(0));
    cur_req = "R6";
    check("R6", 64'(slice(1)), 64'(5'h0e));
    check("R6", 64'(slice(0)), 64'(5'h15));

    cur_req = "R8";
    trig_sel = 0;
    do_write(2, 5'b10_010);
    trgin = 1; tick(4); trgin = 0; tick(2);
    check("R8", 64'(slice(2)), 64'(0));

    cur_req = "R7";
    trig_sel = 1;
    trgin = 1; tick();
    check("R7", 64'(slice(2)), 64'(0));
    tick();
    check("R7", 64'(slice(2)), 64'(5'h12));

    cur_req = "R9";
    do_write(2, 5'b11_111);
    tick(5);
    check("R9", 64'(slice(2)), 64'(5'h12));
    trgin = 0; tick(2);
    trgin = 1; tick(2);
    check("R9", 64'(slice(2)), 64'(5'h1f));
    trgin = 0; tick();

    cur_req = "R10";
    do_write(0, 5'b00_001);
    pulse_comm();
    do_write(0, 5'b10_100);
    check("R10", 64'(slice(0)), 64'(5'h01));
    pulse_comm(); tick();
    check("R10", 64'(slice(0)), 64'(5'h14));

    cur_req = "R3";
    buf_en = 0;
    do_write(1, 5'b10_000);
    check("R3", 64'(slice(1)), 64'(5'h10));

    cur_req = "R1";
    rst = 1; tick(2);
    check("R1", 64'(act_word), 64'(0));
    rst = 0; tick(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule